// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog with a refresh window. Software programs it once through a small register bus. After the enable bit is set, a 6-bit counter starts at 0x3F and counts down. Each count step lasts a selectable number of watchdog clock ticks, and `wd_tick` qualifies those ticks. When the counter reaches a programmed compare value at the end of a step, an interrupt flag is raised. From that point on, software may refresh the counter by writing a fixed key to the reload register.

Two events raise a system reset request, and the request stays up until the block is reset:
- a keyed refresh that arrives while the counter is still above the compare value;
- a counter that runs all the way down to zero.

Software uses the interrupt as its cue to refresh. A refresh is valid only between the interrupt and the final underflow.

Top module: `window_watchdog`

## Requirements
- R1: After reset, the control register reads 0, the count register reads 0x3F, the status register reads 0, and `irq` and `rst_req` are low.
- R2: The first write to the control register (address 0) is accepted, and every later control write is ignored. The control fields are enable (bit 0), interrupt enable (bit 1), prescale select (bits 11:8) and compare value (bits 21:16). The register reads back in the same layout.
- R3: While the enable bit is 0 the counter holds 0x3F, whatever the ticks do.
- R4: Prescale select code c sets how many ticks make one count step. Codes 0 to 7 give 2^c. Codes 8 to 15 give, in order, 192, 256, 384, 512, 768, 1024, 1536 and 2048. The first step after enable ends on the tick that completes that number.
- R5: The interrupt flag (status bit 0, address 2) sets on the tick that ends a step while the counter equals the compare value.
- R6: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R8: A write of 0x00005AA5 to the reload register (address 1) while the counter is at or below the compare value does three things. It sets the counter to 0x3F. It restarts the prescale step. It leaves `rst_req` low.
- R9: A write of any other value to the reload register changes neither the count nor `rst_req`.
- R10: A key write while the counter is above the compare value raises `rst_req` on the next cycle.
- R11: When a step ends with the counter at 0, `rst_req` rises. Once `rst_req` is high it stays high until reset, and a later key write does not lower it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_tick | input | 1 | Watchdog clock enable, one prescaler tick per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 reload, 2 status, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare-match interrupt |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The assertions check the following on every cycle:
- `rst_req` is sticky;
- the control fields stay frozen once locked;
- the counter only ever rises by reloading to 0x3F;
- every rise of the flag is preceded by a step end at the compare value;
- an early key is always followed by a reset request.

The directed scenarios are needed for the rest:
- the exact tick counts of the prescale table;
- the cycle in which the flag and underflow arrive;
- masking of the interrupt;
- the clear-on-one semantics;
- rejection of non-key reload values;
- the restart of the prescale step after a refresh.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int          CNT_W = 6,
  parameter int          PSC_W = 11,
  parameter logic [31:0] KEY   = 32'h0000_5AA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wd_tick,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] A_CTL = 2'd0, A_RLD = 2'd1, A_STS = 2'd2, A_CNT = 2'd3;

  function automatic logic [PSC_W-1:0] step_last(input logic [3:0] code);
    int k, v;
    if (code < 4'd8) v = 1 << code;
    else begin
      k = int'(code) - 8;
      v = k[0] ? (1 << (8 + k / 2)) : (3 << (6 + k / 2));
    end
    return PSC_W'(v - 1);
  endfunction

  logic             en_q, ie_q, locked_q, flag_q, rst_q;
  logic [3:0]       sel_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic [PSC_W-1:0] psc_q;

  wire ctl_wr  = bus_wr && bus_addr == A_CTL && !locked_q;
  wire key_wr  = bus_wr && bus_addr == A_RLD && bus_wdata == KEY && en_q;
  wire early   = key_wr && cnt_q > cmp_q;
  wire refresh = key_wr && !early;
  wire step    = en_q && wd_tick && psc_q == '0;
  wire clr     = bus_wr && bus_addr == A_STS && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; locked_q <= 1'b0;
      sel_q <= '0; cmp_q <= '0;
    end else if (ctl_wr) begin
      en_q     <= bus_wdata[0];
      ie_q     <= bus_wdata[1];
      sel_q    <= bus_wdata[11:8];
      cmp_q    <= bus_wdata[16 +: CNT_W];
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_MAX;
      psc_q <= '0;
    end else if (ctl_wr) begin
      psc_q <= step_last(bus_wdata[11:8]);
    end else if (refresh) begin
      cnt_q <= CNT_MAX;
      psc_q <= step_last(sel_q);
    end else if (en_q && wd_tick) begin
      if (psc_q == '0) begin
        psc_q <= step_last(sel_q);
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end else begin
        psc_q <= psc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (step && cnt_q == cmp_q) flag_q <= 1'b1;
      else if (clr)               flag_q <= 1'b0;
      if (early || (step && cnt_q == '0)) rst_q <= 1'b1;
    end
  end

  assign irq     = flag_q & ie_q;
  assign rst_req = rst_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[0]            = en_q;
        bus_rdata[1]            = ie_q;
        bus_rdata[11:8]         = sel_q;
        bus_rdata[16 +: CNT_W]  = cmp_q;
      end
      A_STS:   bus_rdata[0] = flag_q;
      A_CNT:   bus_rdata[CNT_W-1:0] = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_rst_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_ctl_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(en_q) && $stable(ie_q) && $stable(sel_q) && $stable(cmp_q));

  assert_cnt_rise_only_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |-> cnt_q == CNT_MAX);

  assert_flag_at_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(cnt_q) == cmp_q && $past(psc_q) == '0 && $past(wd_tick)));

  assert_early_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RLD && bus_wdata == KEY && en_q && cnt_q > cmp_q) |=> rst_req);
endmodule

// File: tb/window_watchdog_tb.sv
module window_watchdog_tb;
  logic clk = 1'b0, rst_n = 1'b0, wd_tick = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, rst_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] KEY = 32'h0000_5AA5;

  window_watchdog u_dut (.clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wd_tick = 0; bus_wr = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); wd_tick = 1;
    repeat (n) @(negedge clk);
    wd_tick = 0;
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit ie, input logic [3:0] sel, input logic [5:0] cmp);
    return {10'b0, cmp, 4'b0, sel, 6'b0, ie, en};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(0, d); chk("R1 ctl", d, 0);
    rd(3, d); chk("R1 cnt", d, 32'h3F);
    rd(2, d); chk("R1 sts", d, 0);
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_lock_disabled();
    logic [31:0] d;
    do_reset();
    wr(0, ctl(0, 1, 4'h3, 6'h21));
    wr(0, ctl(1, 0, 4'h0, 6'h05));
    rd(0, d); chk("R2 lock", d, ctl(0, 1, 4'h3, 6'h21));
    ticks(50);
    rd(3, d); chk("R3 disabled hold", d, 32'h3F);
  endtask

  task automatic t_prescale(input logic [3:0] sel, input int n);
    logic [31:0] d;
    do_reset();
    wr(0, ctl(1, 0, sel, 6'h00));
    ticks(n - 1);
    rd(3, d); chk("R4 before step", d, 32'h3F);
    ticks(1);
    rd(3, d); chk("R4 at step", d, 32'h3E);
  endtask

  task automatic t_flag(input bit ie);
    logic [31:0] d;
    do_reset();
    wr(0, ctl(1, ie, 4'h0, 6'h3C));
    ticks(3);
    rd(2, d); chk("R5 flag early", d, 0);
    ticks(1);
    rd(2, d); chk("R5 flag set", d, 1);
    chk("R7 irq", irq, ie);
    wr(2, 0);
    rd(2, d); chk("R6 write0 keeps", d, 1);
    wr(2, 1);
    rd(2, d); chk("R6 clear", d, 0);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    do_reset();
    wr(0, ctl(1, 1, 4'h2, 6'h3E));
    ticks(8);
    rd(2, d); chk("R5 flag psc4", d, 1);
    rd(3, d); chk("R5 cnt after match", d, 32'h3D);
    ticks(1);
    wr(1, KEY);
    rd(3, d); chk("R8 reload", d, 32'h3F);
    chk("R8 no rst", rst_req, 0);
    ticks(3);
    rd(3, d); chk("R8 psc restart", d, 32'h3F);
    ticks(1);
    rd(3, d); chk("R8 step after restart", d, 32'h3E);
  endtask

  task automatic t_badkey();
    logic [31:0] d;
    do_reset();
    wr(0, ctl(1, 0, 4'h0, 6'h3C));
    ticks(4);
    wr(1, 32'h0000_5AA4);
    rd(3, d); chk("R9 bad key cnt", d, 32'h3B);
    chk("R9 bad key rst", rst_req, 0);
  endtask

  task automatic t_early();
    logic [31:0] d;
    do_reset();
    wr(0, ctl(1, 0, 4'h0, 6'h10));
    wr(1, KEY);
    chk("R10 early key", rst_req, 1);
    ticks(47);
    wr(1, KEY);
    chk("R11 sticky", rst_req, 1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    do_reset();
    wr(0, ctl(1, 0, 4'h0, 6'h20));
    ticks(63);
    rd(3, d); chk("R11 cnt zero", d, 0);
    chk("R11 no rst yet", rst_req, 0);
    ticks(1);
    chk("R11 timeout", rst_req, 1);
    repeat (5) @(negedge clk);
    chk("R11 held", rst_req, 1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock_disabled();
    t_prescale(4'h0, 1);
    t_prescale(4'h2, 4);
    t_prescale(4'h8, 192);
    t_prescale(4'hE, 1536);
    t_prescale(4'hF, 2048);
    t_flag(1);
    t_flag(0);
    t_reload();
    t_badkey();
    t_early();
    t_timeout();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule